// File: doc/BRIEF.md
# Precision Time Nanosecond Counter

This block keeps a free-running time of day in nanoseconds for precision time protocol work. On every cycle of its reference clock it adds a programmable fixed-point rate word to an accumulator. The accumulator has a fractional sub-nanosecond part below a 44-bit integer nanosecond count. When the rate word is nominal, the count tracks real time at a 125 MHz reference. Software trims the rate by nudging that word up or down. A rate of zero holds the time still.

Software reaches the block over a plain 32-bit word bus with four registers. Three registers cover the time, split into a 4-bit low field, a 32-bit middle field and an 8-bit top field. The fourth holds the rate word. To load a time, software writes the three time fields one at a time. Each field keeps its written value and continues counting from there. The top byte reads back in data bits [7:0], but a write takes it from data bits [15:8]. Reads of the top and middle fields are separate accesses, and software accepts the 16 ns granularity that results, so the read path has no snapshot latch.

Top module: `ptp_nco_timer`

## Requirements
- R1: After reset the time, the fractional part, the rate word and the read data are all zero, so the counter stays stopped.
- R2: On each cycle with no time-field write, the 72-bit value {time[43:0], frac[27:0]} grows by the 32-bit rate word (its LSB aligned to frac bit 0), modulo 2^72.
- R3: While the rate word is zero and no time field is written, the time does not change. Once a non-zero rate is written, counting resumes from the held value.
- R4: A write to byte address 0x0 loads time[3:0] from wdata[3:0] and clears the fractional part at the next clock edge.
- R5: A write to byte address 0x4 loads time[35:4] from wdata[31:0] at the next clock edge.
- R6: A write to byte address 0x8 loads time[43:36] from wdata[15:8] at the next clock edge. The other data bits, including wdata[7:0], have no effect.
- R7: A write to byte address 0xC loads the rate word from wdata[31:0] at the next edge. The time fields are not overwritten by it, and the new rate first applies on the following edge.
- R8: A read is registered. One cycle after rd_en, rdata shows the value held before that edge: 0x0 gives {28'b0, time[3:0]}, 0x4 gives time[35:4], 0x8 gives {24'b0, time[43:36]}, and 0xC gives the rate word. Without rd_en, rdata holds. Address bits [1:0] are ignored.
- R9: When a time field is written in a cycle that also counts, only the written bits take the written value. All other bits take the sum for that cycle.
- R10: When the count passes 0xFFFFFFFFFFF it wraps to zero and keeps counting, with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Several properties are checked on every cycle: the accumulation step, the freeze under a zero rate, each field load with its bit mapping, the rate load, and the zero upper bits of a read. Other behaviour appears only in the bench's scenarios. This covers the reset values, wrap-around past the top of the count, restarting from a held time, and writes that land in counting cycles. It also covers reads issued in the same cycle as writes, where random mixes are compared against a model of the whole accumulator.

// File: rtl/ptp_nco_pkg.sv
package ptp_nco_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_TOP  = 2'd2,
    SEL_RATE = 2'd3
  } nco_sel_e;

  typedef struct packed {
    logic lo;
    logic mid;
    logic top;
    logic rate;
  } nco_wr_t;
endpackage

// File: rtl/nco_bus_decode.sv
module nco_bus_decode
  import ptp_nco_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output nco_wr_t           wr_sel,
  output nco_sel_e          rd_sel
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int N_WORD = 4;

  logic [N_WORD-1:0] hit;
  logic              unused_lsb;

  assign unused_lsb = ^addr[1:0];

  genvar g;
  generate
    for (g = 0; g < N_WORD; g++) begin : g_word
      assign hit[g] = wr_en && (addr[ADDR_W-1:2] == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    wr_sel.lo   = hit[SEL_LO];
    wr_sel.mid  = hit[SEL_MID];
    wr_sel.top  = hit[SEL_TOP];
    wr_sel.rate = hit[SEL_RATE];
    rd_sel      = nco_sel_e'(addr[3:2]);
  end
endmodule

// File: rtl/nco_time_accum.sv
module nco_time_accum
  import ptp_nco_pkg::*;
#(
  parameter int TIME_W     = 44,
  parameter int FRAC_W     = 28,
  parameter int INC_W      = 32,
  parameter int LO_W       = 4,
  parameter int MID_W      = 32,
  parameter int DATA_W     = 32,
  parameter int TOP_WR_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  nco_wr_t           wr_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [TIME_W-1:0] time_q,
  output logic [INC_W-1:0]  inc_q
);
  localparam int TOP_W = TIME_W - LO_W - MID_W;
  localparam int ACC_W = TIME_W + FRAC_W;

  logic [FRAC_W-1:0] frac_q;
  logic [ACC_W-1:0]  sum;
  logic [TIME_W-1:0] time_nx;
  logic [FRAC_W-1:0] frac_nx;
  logic              any_time_wr;

  assign any_time_wr = wr_sel.lo || wr_sel.mid || wr_sel.top;

  always_comb begin
    sum     = {time_q, frac_q} + ACC_W'(inc_q);
    time_nx = sum[ACC_W-1:FRAC_W];
    frac_nx = sum[FRAC_W-1:0];
    if (wr_sel.lo) begin
      time_nx[LO_W-1:0] = wdata[LO_W-1:0];
      frac_nx           = '0;
    end
    if (wr_sel.mid) time_nx[LO_W +: MID_W] = wdata[MID_W-1:0];
    if (wr_sel.top) time_nx[LO_W+MID_W +: TOP_W] = wdata[TOP_WR_LSB +: TOP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '0;
      frac_q <= '0;
      inc_q  <= '0;
    end else begin
      time_q <= time_nx;
      frac_q <= frac_nx;
      if (wr_sel.rate) inc_q <= wdata[INC_W-1:0];
    end
  end

  // R2
  accum_step_chk: assert property (@(posedge clk) disable iff (rst)
    !any_time_wr |=> {time_q, frac_q} == $past({time_q, frac_q}) + ACC_W'($past(inc_q)));

  // R3
  time_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_q == '0 && !any_time_wr) |=> (time_q == $past(time_q) && frac_q == $past(frac_q)));

  // R4
  lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel.lo |=> (frac_q == '0 && time_q[LO_W-1:0] == $past(wdata[LO_W-1:0])));

  // R5
  mid_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel.mid |=> time_q[LO_W +: MID_W] == $past(wdata[MID_W-1:0]));

  // R6
  top_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel.top |=> time_q[LO_W+MID_W +: TOP_W] == $past(wdata[TOP_WR_LSB +: TOP_W]));

  // R7
  rate_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sel.rate |=> inc_q == $past(wdata[INC_W-1:0]));
endmodule

// File: rtl/nco_read_port.sv
module nco_read_port
  import ptp_nco_pkg::*;
#(
  parameter int TIME_W = 44,
  parameter int INC_W  = 32,
  parameter int LO_W   = 4,
  parameter int MID_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  nco_sel_e          rd_sel,
  input  logic [TIME_W-1:0] time_q,
  input  logic [INC_W-1:0]  inc_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int TOP_W = TIME_W - LO_W - MID_W;

  logic [DATA_W-1:0] mux;

  always_comb begin
    unique case (rd_sel)
      SEL_LO:   mux = DATA_W'(time_q[LO_W-1:0]);
      SEL_MID:  mux = DATA_W'(time_q[LO_W +: MID_W]);
      SEL_TOP:  mux = DATA_W'(time_q[LO_W+MID_W +: TOP_W]);
      default:  mux = DATA_W'(inc_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mux;
  end

  // R8
  top_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == SEL_TOP) |=> rdata[DATA_W-1:TOP_W] == '0);

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/ptp_nco_timer.sv
module ptp_nco_timer
  import ptp_nco_pkg::*;
#(
  parameter int TIME_W     = 44,
  parameter int FRAC_W     = 28,
  parameter int INC_W      = 32,
  parameter int LO_W       = 4,
  parameter int MID_W      = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int TOP_WR_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  nco_wr_t           wr_sel;
  nco_sel_e          rd_sel;
  logic [TIME_W-1:0] time_q;
  logic [INC_W-1:0]  inc_q;

  nco_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en  (bus_wr_en),
    .addr   (bus_addr),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  nco_time_accum #(
    .TIME_W(TIME_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .LO_W(LO_W),
    .MID_W(MID_W), .DATA_W(DATA_W), .TOP_WR_LSB(TOP_WR_LSB)
  ) u_acc (
    .clk    (clk),
    .rst    (rst),
    .wr_sel (wr_sel),
    .wdata  (bus_wdata),
    .time_q (time_q),
    .inc_q  (inc_q)
  );

  nco_read_port #(
    .TIME_W(TIME_W), .INC_W(INC_W), .LO_W(LO_W), .MID_W(MID_W), .DATA_W(DATA_W)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (bus_rd_en),
    .rd_sel (rd_sel),
    .time_q (time_q),
    .inc_q  (inc_q),
    .rdata  (bus_rdata)
  );
endmodule

// File: tb/ptp_nco_timer_test.sv
`timescale 1ns/1ps
module ptp_nco_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptp_nco_timer uut (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  // model: acc = {time[43:0], frac[27:0]}
  logic [71:0] m_acc;
  logic [31:0] m_inc;
  logic [31:0] m_rd;

  function automatic logic [71:0] nx_acc(logic [71:0] cur, logic [31:0] inc,
                                         logic we, logic [3:0] a, logic [31:0] d);
    logic [71:0] s;
    s = cur + {40'd0, inc};
    if (we) begin
      case (a[3:2])
        2'd0: begin s[31:28] = d[3:0]; s[27:0] = '0; end
        2'd1: s[63:32] = d;
        2'd2: s[71:64] = d[15:8];
        default: ;
      endcase
    end
    return s;
  endfunction

  function automatic logic [31:0] rd_val(logic [71:0] acc, logic [31:0] inc, logic [3:0] a);
    case (a[3:2])
      2'd0: return {28'd0, acc[31:28]};
      2'd1: return acc[63:32];
      2'd2: return {24'd0, acc[71:64]};
      default: return inc;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_inc <= '0; m_rd <= '0;
    end else begin
      m_acc <= nx_acc(m_acc, m_inc, wr_en, addr, wdata);
      if (wr_en && addr[3:2] == 2'd3) m_inc <= wdata;
      if (rd_en) m_rd <= rd_val(m_acc, m_inc, addr);
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic rd_model(logic [3:0] a, string req);
    logic [31:0] v;
    bus_rd(a, v);
    check(req, v, m_rd);
  endtask

  task automatic bus_rw(logic [3:0] a, logic [31:0] d, string req);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    check(req, rdata, m_rd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    bus_rd(4'h0, v); check("R1 lo", v, 32'h0);
    bus_rd(4'h4, v); check("R1 mid", v, 32'h0);
    bus_rd(4'h8, v); check("R1 top", v, 32'h0);
    bus_rd(4'hC, v); check("R1 rate", v, 32'h0);

    // R3 frozen with zero rate
    repeat (20) @(negedge clk);
    bus_rd(4'h4, v); check("R3 frozen mid", v, 32'h0);

    // R4 R5 R6 loading a time, low byte of top write ignored
    bus_wr(4'h0, 32'hFFFF_FFF0);
    bus_wr(4'h4, 32'h1234_5678);
    bus_wr(4'h8, 32'h0000_AB55);
    bus_rd(4'h8, v); check("R6 top", v, 32'h0000_00AB);
    bus_rd(4'h4, v); check("R5 mid", v, 32'h1234_5678);
    bus_rd(4'h0, v); check("R4 lo", v, 32'h0);

    // R7 rate write
    bus_wr(4'hC, 32'h8000_0000);
    bus_rd(4'hC, v); check("R7 rate", v, 32'h8000_0000);
    rd_model(4'h4, "R2 running mid");
    rd_model(4'h0, "R2 running lo");

    // R3 stop and resume
    bus_wr(4'hC, 32'h0);
    bus_rd(4'h4, v);
    repeat (10) @(negedge clk);
    bus_rd(4'h4, v2); check("R3 held", v2, v);
    bus_wr(4'hC, 32'h1800_0000);
    repeat (7) @(negedge clk);
    rd_model(4'h4, "R3 resumed");
    rd_model(4'h0, "R3 resumed lo");

    // R10 wrap past the top of the count
    bus_wr(4'hC, 32'h0);
    bus_wr(4'h0, 32'h0000_000F);
    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_wr(4'h8, 32'h0000_FF00);
    bus_rd(4'h8, v); check("R10 preload top", v, 32'h0000_00FF);
    bus_wr(4'hC, 32'h1000_0000);
    bus_rd(4'h8, v); check("R10 wrapped top", v, 32'h0);
    bus_rd(4'h4, v); check("R10 wrapped mid", v, 32'h0);
    rd_model(4'h0, "R10 lo after wrap");

    // R9 writes while counting
    bus_wr(4'hC, 32'h8123_4567);
    bus_wr(4'h4, 32'hFFFF_FFFE);
    rd_model(4'h8, "R9 top after mid write");
    bus_wr(4'h0, 32'h0000_0007);
    rd_model(4'h0, "R9 lo write");
    rd_model(4'h4, "R9 mid after lo write");

    // R8 read in same cycle as write returns old value
    bus_rw(4'h4, 32'hA5A5_A5A5, "R8 read-during-write");
    rd_model(4'h5, "R8 addr lsbs ignored");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [3:0]  a;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      a  = {2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      d  = $urandom;
      if (a[3:2] == 2'd3) begin
        case ($urandom_range(0, 3))
          0: d = 32'h0;
          1: d = 32'h8000_0000;
          default: ;
        endcase
      end
      if (op < 4)      bus_wr(a, d);
      else if (op < 8) rd_model(a, "R8 random read");
      else if (op < 9) bus_rw(a, d, "R9 random rw");
      else             repeat ($urandom_range(1, 5)) @(negedge clk);
    end
    for (int k = 0; k < 4; k++) rd_model(4'(k * 4), "R2 final");

    finish_run();
  end
endmodule